// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two signed two's complement operands of `WIDTH` bits (8 by default) by the add-and-shift method, retiring one multiplier bit per clock. A start pulse captures the multiplicand and the multiplier and clears the partial-product register. The multiplier sits in a shift register whose low bit picks each step's action: add the multiplicand or pass the partial product through. The ALU result and the multiplier register then shift right as one double-width word. The bit entering the top of the partial product is the true sign of the new partial sum. This is the ALU sign bit, inverted whenever the step overflowed. The multiplier's sign bit carries negative weight, so its step subtracts instead of adding.

After the last step the upper half of the product is in the partial-product register and the lower half is in the multiplier register. The block pulses `done` for one cycle and holds the product on its output until the next multiplication is accepted. A controller issues the load and step strobes and keeps the iteration count. A datapath holds the three registers and the ALU.

Top module: `signed_seq_mult`

## Requirements
- R1: When `done` is high, `product` equals the signed product of the captured operands for every pair of signed values, including both operands at the most negative value.
- R2: `busy` rises on the clock edge that accepts `start` and stays high for exactly `WIDTH` cycles, one per multiplier bit.
- R3: `done` is high for exactly one cycle, the cycle right after `busy` falls.
- R4: While the block is idle and no start is accepted, `product` does not change.
- R5: A `start` raised while `busy` is high is ignored: the operands on the inputs are not captured and the running operation keeps its timing and its result.
- R6: Accepting `start` clears the partial product, so a result never depends on the previous operation.
- R7: After reset `busy` and `done` are low and `product` is zero.
- R8: The step for the multiplier's sign bit subtracts the multiplicand, so negative multipliers give correct products.
- R9: The bit shifted into the top of the partial product is the ALU sign inverted on overflow, so steps whose sum leaves the signed range still give correct products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only while idle |
| multiplicand | input | WIDTH | Signed multiplicand, captured on acceptance |
| multiplier | input | WIDTH | Signed multiplier, captured on acceptance |
| busy | output | 1 | High while the iteration steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product, upper half from the accumulator, lower half from the multiplier register |

## Verification
On every cycle the assertions check four things: the product value at `done`, the exact length of `busy`, the single-cycle `done` pulse right after `busy` falls, and a steady product while the block is idle. The need for the overflow-corrected sign bit and for the final subtraction only shows up with particular operands. These are the most negative multiplicand, negative multipliers, and the product of the two most negative values, so the bench runs a corner-value grid and a long random series against its behavioural model. A start raised in the middle of a run and back-to-back runs after a nonzero result can only be shown by bench scenarios, which then compare the result and the timing.

// File: rtl/mult_pkg.sv
package mult_pkg;
  typedef struct packed {
    logic load;       // capture operands, clear partial product
    logic step;       // perform one add/shift iteration
    logic finalStep;  // this iteration handles the multiplier sign bit
  } mulCtrl_t;
endpackage

// File: rtl/mult_control.sv
module mult_control
  import mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output mulCtrl_t ctrl,
  output logic     busy,
  output logic     done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic          busyReg;
  logic          doneReg;
  logic [CW-1:0] stepCnt;

  always_comb begin
    ctrl.load      = start && !busyReg;
    ctrl.step      = busyReg;
    ctrl.finalStep = busyReg && (stepCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyReg <= 1'b0;
      doneReg <= 1'b0;
      stepCnt <= '0;
    end else begin
      doneReg <= ctrl.finalStep;
      if (ctrl.load) begin
        busyReg <= 1'b1;
        stepCnt <= '0;
      end else if (ctrl.finalStep) begin
        busyReg <= 1'b0;
        stepCnt <= '0;
      end else if (busyReg) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign busy = busyReg;
  assign done = doneReg;
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath
  import mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulCtrl_t           ctrl,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] accReg;
  logic [WIDTH-1:0] qReg;
  logic [WIDTH-1:0] mReg;

  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] aluOut;
  logic             doOp;
  logic             ovf;
  logic             signIn;

  always_comb begin
    // subtraction on the sign-bit step: acc + ~m + 1
    addend = ctrl.finalStep ? ~mReg : mReg;
    sum    = accReg + addend + {{(WIDTH-1){1'b0}}, ctrl.finalStep};
    doOp   = qReg[0];
    ovf    = doOp && (accReg[MSB] == addend[MSB]) && (sum[MSB] != accReg[MSB]);
    aluOut = doOp ? sum : accReg;
    signIn = aluOut[MSB] ^ ovf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
      qReg   <= '0;
      mReg   <= '0;
    end else if (ctrl.load) begin
      accReg <= '0;
      qReg   <= multiplier;
      mReg   <= multiplicand;
    end else if (ctrl.step) begin
      accReg <= {signIn, aluOut[MSB:1]};
      qReg   <= {aluOut[0], qReg[MSB:1]};
    end
  end

  assign product = {accReg, qReg};
endmodule

// File: rtl/signed_seq_mult.sv
module signed_seq_mult
  import mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  mulCtrl_t ctrl;

  mult_control #(.WIDTH(WIDTH)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrl),
    .busy (busy),
    .done (done)
  );

  mult_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .multiplicand(multiplicand),
    .multiplier  (multiplier),
    .product     (product)
  );
endmodule

// File: rtl/signed_seq_mult_chk.sv
module signed_seq_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  logic signed [2*WIDTH-1:0] expProd;
  int unsigned               busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expProd <= '0;
      busyLen <= 0;
    end else begin
      if (start && !busy)
        expProd <= (2*WIDTH)'($signed(multiplicand)) * (2*WIDTH)'($signed(multiplier));
      busyLen <= busy ? busyLen + 1 : 0;
    end
  end

  // R1 product value
  a_r1_product_value: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product == expProd));

  // R2 busy length
  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == WIDTH));

  a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyLen < WIDTH));

  // R3 single-cycle done after busy
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_done_follows_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R4 idle hold
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));
endmodule

bind signed_seq_mult signed_seq_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .multiplicand(multiplicand),
  .multiplier  (multiplier),
  .busy        (busy),
  .done        (done),
  .product     (product)
);

// File: tb/sim_signed_seq_mult.sv
`timescale 1ns/1ps
module sim_signed_seq_mult;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // reference model state
  bit          mBusy = 0;
  bit          mDone = 0;
  int          mCnt = 0;
  longint      mProd = 0;
  longint      mPend = 0;

  always #2.5 clk = ~clk;

  signed_seq_mult #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(mcand), .multiplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  function automatic longint sx(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [2*W-1:0] asBits(input longint v);
    return v[2*W-1:0];
  endfunction

  // behavioural model, advanced on each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0; mProd = 0; mPend = 0;
    end else begin
      mDone = mBusy && (mCnt == W - 1);
      if (mBusy) begin
        if (mCnt == W - 1) begin
          mBusy = 0;
          mProd = mPend;
        end else begin
          mCnt++;
        end
      end else if (start) begin
        mBusy = 1;
        mCnt  = 0;
        mPend = sx(mcand) * sx(mplier);
      end
    end
  end

  // compare on every falling edge (R2, R3, R4, R1)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      vectors++;
      if (busy !== mBusy) begin
        miscompares++;
        $display("FAIL R2 busy: got %0b expected %0b at %0t", busy, mBusy, $time);
      end
      vectors++;
      if (done !== mDone) begin
        miscompares++;
        $display("FAIL R3 done: got %0b expected %0b at %0t", done, mDone, $time);
      end
      if (!mBusy) begin
        vectors++;
        if (product !== asBits(mProd)) begin
          miscompares++;
          $display("FAIL R1/R4 product: got %h expected %h at %0t", product, asBits(mProd), $time);
        end
      end
    end
  end

  task automatic checkNow(input string tag, input longint expVal);
    vectors++;
    if (product !== asBits(expVal)) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, product, asBits(expVal));
    end
  endtask

  // run one multiplication; optionally raise a stray start mid-run
  task automatic runMul(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit stray, input string tag);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    mcand = $urandom; mplier = $urandom;
    for (int i = 0; i < W; i++) begin
      if (stray && i == 3) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    // now in the done cycle
    checkNow(tag, sx(a) * sx(b));
  endtask

  initial begin
    #200000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corner [10];
    corner = '{8'h80, 8'h81, 8'hFF, 8'h00, 8'h01, 8'h7F, 8'h40, 8'hC0, 8'h55, 8'hAA};
    repeat (3) @(negedge clk);
    // R7 reset state
    vectors++;
    if (busy !== 1'b0 || done !== 1'b0 || product !== '0) begin
      miscompares++;
      $display("FAIL R7 reset: got busy=%0b done=%0b product=%h expected 0 0 0000", busy, done, product);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runMul(8'h05, 8'h03, 0, "R1 small positive");
    runMul(8'h05, 8'hFF, 0, "R8 negative multiplier");
    runMul(8'h80, 8'h80, 0, "R9 most negative squared");
    runMul(8'h80, 8'h7F, 0, "R9 overflow multiplicand");
    runMul(8'h7F, 8'h80, 0, "R8 most negative multiplier");
    // R6: previous result nonzero, next must not inherit it
    runMul(8'h00, 8'h00, 0, "R6 clear after prior result");
    // R5: stray start with different operands mid-run
    runMul(8'hC3, 8'h5A, 1, "R5 stray start ignored");
    runMul(8'h12, 8'hED, 1, "R5 stray start ignored again");
    // R4: idle for a while, product held (compared each cycle)
    repeat (20) @(negedge clk);
    checkNow("R4 held while idle", sx(8'h12) * sx(8'hED));

    foreach (corner[i])
      foreach (corner[j])
        runMul(corner[i], corner[j], 0, "R9 corner grid");

    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      runMul(ra, rb, (k % 7) == 0, "R1 random");
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule